// File: doc/BRIEF.md
# Grouped Interrupt Controller

This block gathers sixteen external interrupt request pins and folds them onto four CPU interrupt lines and one dedicated non-maskable line. Pins 1 to 14 are active-low level sources. Pin 15 is a button that counts only on a falling edge, and it drives the non-maskable line. Pin 0 has no function. Every pin first passes through a two-flop synchroniser. After that, a pending flag per pin records the request.

Software sees two 16-bit registers on a simple single-cycle bus. The first is a mask, where a 1 blocks the pin. The second is the pending flags, which are acknowledged by writing a 0 to the bits to be cleared. Each CPU line is the OR, over a fixed scattered set of pins, of "pending and not masked". All outputs and the read data are registered.

Top module: `grp_irq_ctrl`

## Requirements
- R1: After a synchronous reset the mask reads 0xFFFF, the flags read 0x0000, and `cpu_irq`, `nmi` and `bus_rdata` are all 0.
- R2: The mask register sits at bus address 0x4 and reads back what was written there. A mask bit of 1 keeps the pin's flag off every output, but the flag is still captured. A mask bit of 0 lets the flag through.
- R3: The flag register sits at bus address 0xC and reads back the current flags. Bit 0 always reads 0, whatever `src_n[0]` does.
- R4: A write to address 0xC clears each flag whose written bit is 0. Each flag whose written bit is 1 keeps its value.
- R5: For pins 1 to 14, the flag is set on every clock in which the synchronised pin is low. An acknowledge that falls while the pin is still low shows the flag as 0 for exactly one cycle, after which the flag is set again.
- R6: `cpu_irq[0]` covers pins {3,5} (0x0028). `cpu_irq[1]` covers {4,6} (0x0050). `cpu_irq[2]` covers {10,11,12} (0x1C00). `cpu_irq[3]` covers {1,2,7,8,9,13,14} (0x6386). Each line is the OR of flag AND NOT mask over its set.
- R7: Pin 15 sets its flag only on a high-to-low transition of the synchronised pin. The flag then holds until it is cleared. Holding the pin low after a clear does not set the flag again.
- R8: `nmi` is high exactly when flag 15 is set and mask bit 15 is 0.
- R9: A pin change reaches the flag on the third rising edge after it. The outputs follow one edge after any flag or mask change, so the output responds on the fourth edge.
- R10: Reads from any address other than 0x4 and 0xC return 0. Writes to any other address change nothing.
- R11: `bus_rdata` is loaded on the edge that samples `bus_addr`. It shows the register values from before any write that lands on that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 4 | Register address |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| src_n | input | 16 | Asynchronous interrupt pins (bit 0 unused) |
| cpu_irq | output | 4 | Grouped CPU interrupt lines, active high |
| nmi | output | 1 | Non-maskable interrupt line, active high |

## Verification
A wrong flag or mask bit shows up one edge later. It appears on the `cpu_irq` line of its group, or on `nmi`, and in the next read of the flag or mask register. A fault in the synchroniser or the edge detector moves the output's response away from the fourth edge, or makes pin 15 fire again while it is held low. For these reasons the bench compares all outputs against an independent cycle model on every clock. It also runs directed sequences for acknowledge timing, masking, edge behaviour and address decoding.

// File: rtl/gic_pkg.sv
package gic_pkg;

  localparam int SRC_W  = 16;
  localparam int OUT_N  = 4;
  localparam int BUS_AW = 4;

  localparam logic [BUS_AW-1:0] ADDR_MASK = 4'h4;
  localparam logic [BUS_AW-1:0] ADDR_FLAG = 4'hC;

  // group membership, element g drives cpu line g
  localparam logic [OUT_N-1:0][SRC_W-1:0] DEFAULT_GROUPS =
    {16'h6386, 16'h1C00, 16'h0050, 16'h0028};

  typedef enum logic [1:0] {
    SRC_NONE  = 2'd0,
    SRC_LEVEL = 2'd1,
    SRC_EDGE  = 2'd2
  } src_kind_e;

  function automatic src_kind_e kind_of(input int idx, input int edge_idx);
    if (idx == 0)
      return SRC_NONE;
    else if (idx == edge_idx)
      return SRC_EDGE;
    else
      return SRC_LEVEL;
  endfunction

endpackage

// File: rtl/gic_sync.sv
module gic_sync #(
  parameter int             W       = 16,
  parameter int             STAGES  = 2,
  parameter logic [W-1:0]   RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [STAGES-1:0][W-1:0] stage_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage_q <= {STAGES{RST_VAL}};
    end else begin
      stage_q[0] <= d;
      for (int s = 1; s < STAGES; s++)
        stage_q[s] <= stage_q[s-1];
    end
  end

  assign q = stage_q[STAGES-1];

endmodule

// File: rtl/gic_flag_bank.sv
module gic_flag_bank #(
  parameter int W        = 16,
  parameter int EDGE_BIT = 15
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] lvl_n,
  input  logic         clr_en,
  input  logic [W-1:0] clr_keep,
  output logic [W-1:0] flags
);

  import gic_pkg::*;

  logic [W-1:0] flag_q;
  logic [W-1:0] set_v;
  logic [W-1:0] clr_v;
  logic         edge_prev_q;

  assign clr_v = {W{clr_en}} & ~clr_keep;

  // previous synchronised level of the edge source
  always_ff @(posedge clk) begin
    if (rst)
      edge_prev_q <= 1'b1;
    else
      edge_prev_q <= lvl_n[EDGE_BIT];
  end

  for (genvar i = 0; i < W; i++) begin : g_bit
    if (kind_of(i, EDGE_BIT) == SRC_NONE) begin : g_none
      logic unused_pin;
      assign unused_pin = lvl_n[i];
      assign set_v[i]   = 1'b0;
    end else if (kind_of(i, EDGE_BIT) == SRC_EDGE) begin : g_edge
      assign set_v[i] = edge_prev_q & ~lvl_n[i];

      // R7: a set flag survives until a clear
      a_r7_edge_hold: assert property (@(posedge clk) disable iff (rst)
        (flag_q[i] && !clr_v[i]) |=> flag_q[i]);
      // R7: no falling edge and no prior flag, no flag
      a_r7_edge_only: assert property (@(posedge clk) disable iff (rst)
        (!flag_q[i] && !(edge_prev_q && !lvl_n[i])) |=> !flag_q[i]);
    end else begin : g_level
      assign set_v[i] = ~lvl_n[i];

      // R5: low level without clear sets the flag
      a_r5_level_set: assert property (@(posedge clk) disable iff (rst)
        (!lvl_n[i] && !clr_v[i]) |=> flag_q[i]);
    end

    // R4: a zero written to the flag register clears that bit
    a_r4_clear_bit: assert property (@(posedge clk) disable iff (rst)
      clr_v[i] |=> !flag_q[i]);
  end

  // clear has priority over set in the same cycle
  always_ff @(posedge clk) begin
    if (rst)
      flag_q <= '0;
    else
      flag_q <= (flag_q | set_v) & ~clr_v;
  end

  assign flags = flag_q;

endmodule

// File: rtl/gic_regs.sv
module gic_regs #(
  parameter int                W         = 16,
  parameter int                AW        = 4,
  parameter logic [AW-1:0]     MASK_ADDR = 4'h4,
  parameter logic [AW-1:0]     FLAG_ADDR = 4'hC,
  parameter logic [W-1:0]      MASK_RST  = '1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_we,
  input  logic [W-1:0]  bus_wdata,
  input  logic [W-1:0]  flags_in,
  output logic [W-1:0]  mask_out,
  output logic          flag_clr_en,
  output logic [W-1:0]  bus_rdata
);

  logic [W-1:0] mask_q;
  logic [W-1:0] rdata_q;
  logic         hit_mask;
  logic         hit_flag;

  assign hit_mask    = (bus_addr == MASK_ADDR);
  assign hit_flag    = (bus_addr == FLAG_ADDR);
  assign flag_clr_en = bus_we & hit_flag;

  always_ff @(posedge clk) begin
    if (rst)
      mask_q <= MASK_RST;
    else if (bus_we && hit_mask)
      mask_q <= bus_wdata;
  end

  always_ff @(posedge clk) begin
    if (rst)
      rdata_q <= '0;
    else if (hit_mask)
      rdata_q <= mask_q;
    else if (hit_flag)
      rdata_q <= flags_in;
    else
      rdata_q <= '0;
  end

  assign mask_out  = mask_q;
  assign bus_rdata = rdata_q;

  // R2: mask write lands on the next edge
  a_r2_mask_load: assert property (@(posedge clk) disable iff (rst)
    (bus_we && hit_mask) |=> (mask_q == $past(bus_wdata)));
  // R10: the mask only moves on a mask write
  a_r10_mask_steady: assert property (@(posedge clk) disable iff (rst)
    !(bus_we && hit_mask) |=> $stable(mask_q));
  // R11: flag read shows the pre-edge flags
  a_r11_flag_read: assert property (@(posedge clk) disable iff (rst)
    hit_flag |=> (bus_rdata == $past(flags_in)));
  // R10: unmapped reads return zero
  a_r10_hole_zero: assert property (@(posedge clk) disable iff (rst)
    (!hit_mask && !hit_flag) |=> (bus_rdata == '0));

endmodule

// File: rtl/gic_group_out.sv
module gic_group_out #(
  parameter int                          W         = 16,
  parameter int                          N_OUT     = 4,
  parameter int                          EDGE_BIT  = 15,
  parameter logic [N_OUT-1:0][W-1:0]     GROUP_MAP = gic_pkg::DEFAULT_GROUPS
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [W-1:0]     flags,
  input  logic [W-1:0]     mask,
  output logic [N_OUT-1:0] cpu_irq,
  output logic             nmi
);

  logic [W-1:0]     live;
  logic [N_OUT-1:0] irq_q;
  logic             nmi_q;

  assign live = flags & ~mask;

  for (genvar g = 0; g < N_OUT; g++) begin : g_line
    always_ff @(posedge clk) begin
      if (rst)
        irq_q[g] <= 1'b0;
      else
        irq_q[g] <= |(live & GROUP_MAP[g]);
    end

    // R6: any live member raises the line one edge later
    a_r6_line_on: assert property (@(posedge clk) disable iff (rst)
      (|(flags & ~mask & GROUP_MAP[g])) |=> cpu_irq[g]);
    // R6: no live member keeps the line low
    a_r6_line_off: assert property (@(posedge clk) disable iff (rst)
      !(|(flags & ~mask & GROUP_MAP[g])) |=> !cpu_irq[g]);
  end

  always_ff @(posedge clk) begin
    if (rst)
      nmi_q <= 1'b0;
    else
      nmi_q <= live[EDGE_BIT];
  end

  assign cpu_irq = irq_q;
  assign nmi     = nmi_q;

  // R8: pending and enabled edge source drives nmi
  a_r8_nmi_on: assert property (@(posedge clk) disable iff (rst)
    (flags[EDGE_BIT] && !mask[EDGE_BIT]) |=> nmi);
  // R8: masked or idle edge source keeps nmi low
  a_r8_nmi_off: assert property (@(posedge clk) disable iff (rst)
    !(flags[EDGE_BIT] && !mask[EDGE_BIT]) |=> !nmi);

endmodule

// File: rtl/grp_irq_ctrl.sv
module grp_irq_ctrl #(
  parameter int                                DATA_W      = gic_pkg::SRC_W,
  parameter int                                ADDR_W      = gic_pkg::BUS_AW,
  parameter int                                N_OUT       = gic_pkg::OUT_N,
  parameter int                                SYNC_STAGES = 2,
  parameter int                                EDGE_BIT    = 15,
  parameter logic [ADDR_W-1:0]                 MASK_ADDR   = gic_pkg::ADDR_MASK,
  parameter logic [ADDR_W-1:0]                 FLAG_ADDR   = gic_pkg::ADDR_FLAG,
  parameter logic [N_OUT-1:0][DATA_W-1:0]      GROUP_MAP   = gic_pkg::DEFAULT_GROUPS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [DATA_W-1:0] src_n,
  output logic [N_OUT-1:0]  cpu_irq,
  output logic              nmi
);

  localparam logic [DATA_W-1:0] IDLE_LEVEL = '1;

  logic [DATA_W-1:0] src_sync_n;
  logic [DATA_W-1:0] flags;
  logic [DATA_W-1:0] mask;
  logic              flag_clr_en;

  gic_sync #(
    .W       (DATA_W),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (IDLE_LEVEL)
  ) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (src_n),
    .q   (src_sync_n)
  );

  gic_flag_bank #(
    .W        (DATA_W),
    .EDGE_BIT (EDGE_BIT)
  ) u_flags (
    .clk      (clk),
    .rst      (rst),
    .lvl_n    (src_sync_n),
    .clr_en   (flag_clr_en),
    .clr_keep (bus_wdata),
    .flags    (flags)
  );

  gic_regs #(
    .W         (DATA_W),
    .AW        (ADDR_W),
    .MASK_ADDR (MASK_ADDR),
    .FLAG_ADDR (FLAG_ADDR),
    .MASK_RST  ('1)
  ) u_regs (
    .clk         (clk),
    .rst         (rst),
    .bus_addr    (bus_addr),
    .bus_we      (bus_we),
    .bus_wdata   (bus_wdata),
    .flags_in    (flags),
    .mask_out    (mask),
    .flag_clr_en (flag_clr_en),
    .bus_rdata   (bus_rdata)
  );

  gic_group_out #(
    .W         (DATA_W),
    .N_OUT     (N_OUT),
    .EDGE_BIT  (EDGE_BIT),
    .GROUP_MAP (GROUP_MAP)
  ) u_out (
    .clk     (clk),
    .rst     (rst),
    .flags   (flags),
    .mask    (mask),
    .cpu_irq (cpu_irq),
    .nmi     (nmi)
  );

  // R3: pin 0 never produces a flag
  a_r3_pin0_idle: assert property (@(posedge clk) disable iff (rst)
    !flags[0]);
  // R1: first cycle after reset shows the reset register state
  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (mask == '1 && flags == '0 && cpu_irq == '0 && !nmi));

endmodule

// File: tb/grp_irq_ctrl_tb_top.sv
module grp_irq_ctrl_tb_top;

  localparam logic [3:0] A_MASK = 4'h4;
  localparam logic [3:0] A_FLAG = 4'hC;
  localparam logic [15:0] GRP [4] = '{16'h0028, 16'h0050, 16'h1C00, 16'h6386};

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  bus_addr = 4'h0;
  logic        bus_we = 1'b0;
  logic [15:0] bus_wdata = 16'h0;
  logic [15:0] bus_rdata;
  logic [15:0] src_n = 16'hFFFF;
  logic [3:0]  cpu_irq;
  logic        nmi;

  always #4 clk = ~clk;

  grp_irq_ctrl dut_i (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .src_n     (src_n),
    .cpu_irq   (cpu_irq),
    .nmi       (nmi)
  );

  int n_vec = 0;
  int n_bad = 0;
  bit cmp_en = 1'b0;

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural cycle model
  logic [15:0] m_s1, m_s2, m_flags, m_mask, m_rd, m_nf;
  logic        m_prev, m_nmi, m_clr, m_set;
  logic [3:0]  m_irq;

  always @(posedge clk) begin
    if (rst) begin
      m_s1 = 16'hFFFF; m_s2 = 16'hFFFF; m_prev = 1'b1;
      m_flags = 16'h0; m_mask = 16'hFFFF; m_rd = 16'h0;
      m_irq = 4'h0; m_nmi = 1'b0;
    end else begin
      if (bus_addr == A_MASK)      m_rd = m_mask;
      else if (bus_addr == A_FLAG) m_rd = m_flags;
      else                         m_rd = 16'h0;
      for (int g = 0; g < 4; g++) m_irq[g] = |(m_flags & ~m_mask & GRP[g]);
      m_nmi = m_flags[15] & ~m_mask[15];
      m_nf = m_flags;
      for (int i = 1; i < 16; i++) begin
        m_clr = bus_we && (bus_addr == A_FLAG) && !bus_wdata[i];
        m_set = (i == 15) ? (m_prev && !m_s2[15]) : !m_s2[i];
        if (m_clr)      m_nf[i] = 1'b0;
        else if (m_set) m_nf[i] = 1'b1;
      end
      m_nf[0] = 1'b0;
      if (bus_we && bus_addr == A_MASK) m_mask = bus_wdata;
      m_flags = m_nf;
      m_prev  = m_s2[15];
      m_s2    = m_s1;
      m_s1    = src_n;
    end
  end

  always @(posedge clk) begin
    #2;
    if (cmp_en) begin
      chk("R6 cpu_irq vs model", {12'h0, cpu_irq}, {12'h0, m_irq});
      chk("R8 nmi vs model", {15'h0, nmi}, {15'h0, m_nmi});
      chk("R11 rdata vs model", bus_rdata, m_rd);
    end
  end

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0; bus_addr = 4'h0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [15:0] exp, input string tag);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b0;
    @(posedge clk);
    #2;
    chk(tag, bus_rdata, exp);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(input int bit_i);
    @(negedge clk);
    src_n[bit_i] = 1'b0;
    @(negedge clk);
    src_n[bit_i] = 1'b1;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    @(negedge clk);
    cmp_en = 1'b1;
    idle(2);
    rst = 1'b0;

    // R1: reset state
    chk("R1 cpu_irq after reset", {12'h0, cpu_irq}, 16'h0);
    chk("R1 nmi after reset", {15'h0, nmi}, 16'h0);
    rd(A_MASK, 16'hFFFF, "R1 mask reset value");
    rd(A_FLAG, 16'h0000, "R1 flags reset value");

    // R2: enable everything
    wr(A_MASK, 16'h0000);
    rd(A_MASK, 16'h0000, "R2 mask readback");

    // R9: pin 4 low reaches cpu_irq[1] on the fourth edge
    @(negedge clk);
    src_n[4] = 1'b0;
    for (int k = 1; k <= 4; k++) begin
      @(posedge clk);
      #2;
      chk("R9 latency to cpu_irq[1]", {15'h0, cpu_irq[1]}, (k == 4) ? 16'h1 : 16'h0);
    end
    idle(1);
    rd(A_FLAG, 16'h0010, "R5 level flag set");
    chk("R6 group 1 for pin 4", {12'h0, cpu_irq}, 16'h0002);

    // R5: acknowledge while still low clears for one cycle only
    @(negedge clk);
    bus_addr = A_FLAG; bus_we = 1'b1; bus_wdata = 16'hFFEF;
    @(posedge clk); #2;
    @(negedge clk);
    bus_we = 1'b0;
    @(posedge clk); #2;
    chk("R5 flag cleared for one cycle", bus_rdata, 16'h0000);
    @(posedge clk); #2;
    chk("R5 flag set again while low", bus_rdata, 16'h0010);
    @(negedge clk);
    src_n[4] = 1'b1;
    idle(4);
    wr(A_FLAG, 16'h0000);
    rd(A_FLAG, 16'h0000, "R4 clear with zeros");

    // R6: every level pin lands on its own group line
    for (int i = 1; i < 15; i++) begin
      logic [3:0] exp_l;
      pulse(i);
      idle(5);
      for (int g = 0; g < 4; g++) exp_l[g] = GRP[g][i];
      chk($sformatf("R6 group map pin %0d", i), {12'h0, cpu_irq}, {12'h0, exp_l});
      wr(A_FLAG, 16'h0000);
      idle(2);
    end

    // R4: ones keep flags, zeros clear
    pulse(3);
    pulse(10);
    idle(5);
    wr(A_FLAG, 16'hFBFF);
    rd(A_FLAG, 16'h0008, "R4 written ones keep flags");
    wr(A_FLAG, 16'h0000);

    // R2: masked flag is captured but silent
    wr(A_MASK, 16'h0028);
    pulse(5);
    idle(5);
    chk("R2 masked pin silent", {12'h0, cpu_irq}, 16'h0000);
    rd(A_FLAG, 16'h0020, "R2 masked flag still captured");
    wr(A_MASK, 16'h0000);
    idle(1);
    chk("R2 unmask releases line", {12'h0, cpu_irq}, 16'h0001);
    wr(A_FLAG, 16'h0000);

    // R7: edge source
    @(negedge clk);
    src_n[15] = 1'b0;
    idle(5);
    chk("R7 falling edge raises nmi", {15'h0, nmi}, 16'h1);
    rd(A_FLAG, 16'h8000, "R7 edge flag set");
    wr(A_FLAG, 16'h7FFF);
    idle(4);
    chk("R7 held low does not refire", {15'h0, nmi}, 16'h0);
    rd(A_FLAG, 16'h0000, "R7 flag stays clear while low");
    @(negedge clk);
    src_n[15] = 1'b1;
    idle(4);
    chk("R7 rising edge ignored", {15'h0, nmi}, 16'h0);
    @(negedge clk);
    src_n[15] = 1'b0;
    idle(5);
    chk("R7 second edge raises nmi", {15'h0, nmi}, 16'h1);

    // R8: mask bit 15 gates nmi
    wr(A_MASK, 16'h8000);
    idle(1);
    chk("R8 masked nmi low", {15'h0, nmi}, 16'h0);
    rd(A_FLAG, 16'h8000, "R8 nmi flag held under mask");
    wr(A_MASK, 16'h0000);
    idle(1);
    chk("R8 unmasked nmi high", {15'h0, nmi}, 16'h1);
    @(negedge clk);
    src_n[15] = 1'b1;
    wr(A_FLAG, 16'h0000);
    idle(3);

    // R3: pin 0 has no effect
    @(negedge clk);
    src_n[0] = 1'b0;
    idle(5);
    rd(A_FLAG, 16'h0000, "R3 pin 0 flag stays zero");
    chk("R3 pin 0 no output", {12'h0, cpu_irq}, 16'h0000);
    @(negedge clk);
    src_n[0] = 1'b1;

    // R10: unmapped addresses
    wr(A_MASK, 16'hFFFF);
    pulse(3);
    idle(5);
    wr(4'h0, 16'h0000);
    wr(4'h8, 16'h0000);
    rd(A_MASK, 16'hFFFF, "R10 stray write leaves mask");
    rd(A_FLAG, 16'h0008, "R10 stray write leaves flags");
    rd(4'h2, 16'h0000, "R10 unmapped read is zero");
    wr(A_MASK, 16'h0000);
    wr(A_FLAG, 16'h0000);

    // R11: read during write shows old value
    @(negedge clk);
    bus_addr = A_MASK; bus_we = 1'b1; bus_wdata = 16'h1234;
    @(posedge clk); #2;
    chk("R11 read shows pre-write mask", bus_rdata, 16'h0000);
    @(negedge clk);
    bus_we = 1'b0;
    @(posedge clk); #2;
    chk("R11 read shows new mask", bus_rdata, 16'h1234);
    wr(A_MASK, 16'h0000);

    // mixed traffic against the model
    for (int c = 0; c < 600; c++) begin
      @(negedge clk);
      src_n = 16'($urandom) | 16'($urandom);
      if (($urandom % 8) == 0) begin
        int sel = $urandom % 3;
        bus_addr  = (sel == 0) ? A_MASK : (sel == 1) ? A_FLAG : 4'($urandom);
        bus_we    = 1'b1;
        bus_wdata = 16'($urandom);
      end else begin
        bus_we   = 1'b0;
        bus_addr = (($urandom % 2) == 0) ? A_FLAG : A_MASK;
      end
    end
    @(negedge clk);
    bus_we = 1'b0;
    idle(3);
    finish_run();
  end

endmodule